// File: doc/BRIEF.md
# UART Status Flags and Interrupt Request Unit

This block holds the six status flags of an asynchronous serial port and turns them into interrupt requests. The flags are receive-data-full, transmit-holding-empty, transmit-line-idle, and the three receive errors: parity, framing and overrun. The receiver and transmitter report events to it as single-cycle strobes. The host interface reports register reads and writes to it the same way. The block also keeps the last accepted receive byte, so that an overrun can leave that byte untouched.

The unit registers no configuration of its own. The receive enable and the three interrupt enables come in as level inputs, so a software reset cannot change them. A software-reset strobe puts every flag back to its power-up value and drives the request-to-send output low. In the following cycle it also raises an abort pulse, which the serial engines use to drop any frame in progress and reload their baud counter. A single error-clear strobe wipes all three error flags at once. When a set event and a clear event hit the same flag in the same cycle, the set wins.

Top module: `uart_flag_irq`

## Requirements
- R1: With reset asserted, and in the cycles right after it, tx_empty_o and line_idle_o are 1. rx_full_o, parity_err_o, frame_err_o, overrun_err_o, rts_o and abort_o are 0, and rx_data_o is all zeros.
- R2: A byte is accepted when rx_load_i=1 and rx_en_i=1, unless it overruns (R3). At the next edge an accepted byte sets rx_full_o and is copied to rx_data_o. data_read_i=1 clears rx_full_o at the next edge. If a load and a read arrive in the same cycle, the load wins and rx_full_o stays 1.
- R3: An overrun is a load with rx_en_i=1 while rx_full_o=1 and data_read_i=0. It sets overrun_err_o and leaves rx_data_o, rx_full_o, parity_err_o and frame_err_o unchanged.
- R4: An accepted byte sets parity_err_o if rx_parity_bad_i=1 and sets frame_err_o if rx_frame_bad_i=1. Error flags stay set until they are cleared.
- R5: err_clr_i=1 clears all three error flags at the next edge. If a load in the same cycle sets an error flag, that flag ends up 1.
- R6: tx_write_i=1 clears tx_empty_o. tx_take_i=1 sets it. If both arrive in the same cycle, tx_empty_o ends up 1.
- R7: tx_take_i=1 clears line_idle_o. tx_done_i=1 sets it. If both arrive in the same cycle, line_idle_o ends up 1.
- R8: rx_irq_o is 1 exactly when rx_ie_i=1 and at least one of rx_full_o, parity_err_o, frame_err_o or overrun_err_o is 1. It follows its inputs in the same cycle.
- R9: tx_irq_o equals tx_ie_i AND tx_empty_o. idle_irq_o equals idle_ie_i AND line_idle_o. Both follow their inputs in the same cycle.
- R10: sw_reset_i=1 overrides every other strobe. At the next edge the flags take their R1 values and rx_data_o keeps its value. abort_o is 1 in exactly the cycle after each cycle with sw_reset_i=1.
- R11: rts_o equals rx_en_i of the previous cycle, and is 0 in the cycle after sw_reset_i=1.
- R12: With rx_en_i=0, rx_load_i has no effect on rx_full_o, rx_data_o or the error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sw_reset_i | input | 1 | Host wrote 1 to the software-reset bit |
| err_clr_i | input | 1 | Host wrote 1 to the error-clear bit |
| rx_en_i | input | 1 | Receive enable |
| rx_ie_i | input | 1 | Receive interrupt enable |
| tx_ie_i | input | 1 | Transmit interrupt enable |
| idle_ie_i | input | 1 | Line-idle interrupt enable |
| rx_load_i | input | 1 | Receiver completed a byte |
| rx_byte_i | input | DATA_W | Completed byte |
| rx_parity_bad_i | input | 1 | Completed byte had a parity error |
| rx_frame_bad_i | input | 1 | Completed byte had a framing error |
| data_read_i | input | 1 | Host read the receive data register |
| tx_write_i | input | 1 | Host wrote the transmit holding register |
| tx_take_i | input | 1 | Transmitter moved the held byte into its shifter |
| tx_done_i | input | 1 | Transmitter finished the last frame |
| rx_data_o | output | DATA_W | Last accepted byte |
| rx_full_o | output | 1 | Receive data full |
| parity_err_o | output | 1 | Parity error flag |
| frame_err_o | output | 1 | Framing error flag |
| overrun_err_o | output | 1 | Overrun error flag |
| tx_empty_o | output | 1 | Transmit holding register empty |
| line_idle_o | output | 1 | Transmit line idle |
| rx_irq_o | output | 1 | Receive interrupt request |
| tx_irq_o | output | 1 | Transmit interrupt request |
| idle_irq_o | output | 1 | Line-idle interrupt request |
| rts_o | output | 1 | Request to send |
| abort_o | output | 1 | One-cycle abort and baud-reload pulse |

## Verification
The hardest cases to reach are the collisions. The first is a new byte arriving while the old one is unread, with the host's read landing in the same cycle or one cycle late. The second is a load carrying a parity or framing error that coincides with the error-clear strobe. The third is a software reset that lands on top of other strobes. Random stimulus drives every strobe at a high rate, so the full-flag collision and the overrun both occur often, and a bench model predicts every output each cycle. Directed sequences then force each collision, the receive-disabled load, and software reset against live strobes, one by one.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
  typedef struct packed {
    logic parity;
    logic frame;
    logic overrun;
  } rx_err_t;

  localparam rx_err_t RX_ERR_NONE = '{parity: 1'b0, frame: 1'b0, overrun: 1'b0};
endpackage

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
  import uart_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_reset,
  input  logic              rx_en,
  input  logic              rx_load,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              par_bad,
  input  logic              frm_bad,
  input  logic              data_read,
  input  logic              err_clr,
  output logic              full,
  output rx_err_t           err,
  output logic [DATA_W-1:0] data
);

  logic              full_q, full_d;
  rx_err_t           err_q, err_d;
  logic [DATA_W-1:0] data_q;
  logic              accept, ovr_evt, store;

  always_comb begin
    accept  = rx_load & rx_en;
    ovr_evt = accept & full_q & ~data_read;
    store   = accept & ~ovr_evt & ~sw_reset;

    full_d = full_q;
    if (data_read) full_d = 1'b0;
    if (store)     full_d = 1'b1;
    if (sw_reset)  full_d = 1'b0;

    err_d = err_q;
    if (err_clr) err_d = RX_ERR_NONE;
    if (store) begin
      if (par_bad) err_d.parity = 1'b1;
      if (frm_bad) err_d.frame  = 1'b1;
    end
    if (ovr_evt)  err_d.overrun = 1'b1;
    if (sw_reset) err_d = RX_ERR_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      err_q  <= RX_ERR_NONE;
    end else begin
      full_q <= full_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (store) begin
      data_q <= rx_byte;
    end
  end

  assign full = full_q;
  assign err  = err_q;
  assign data = data_q;

  // R3
  overrun_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_load && rx_en && full_q && !data_read && !sw_reset)
      |=> (err_q.overrun && full_q && $stable(data_q)));

  // R5
  err_clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !rx_load) |=> (err_q == RX_ERR_NONE));

  // R12
  rx_disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !sw_reset && !data_read) |=> ($stable(full_q) && $stable(data_q)));

endmodule

// File: rtl/uart_tx_flags.sv
module uart_tx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_reset,
  input  logic tx_write,
  input  logic tx_take,
  input  logic tx_done,
  output logic empty,
  output logic idle
);

  logic empty_q, empty_d, idle_q, idle_d;

  always_comb begin
    empty_d = empty_q;
    if (tx_write) empty_d = 1'b0;
    if (tx_take)  empty_d = 1'b1;
    if (sw_reset) empty_d = 1'b1;

    idle_d = idle_q;
    if (tx_take)  idle_d = 1'b0;
    if (tx_done)  idle_d = 1'b1;
    if (sw_reset) idle_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      idle_q  <= 1'b1;
    end else begin
      empty_q <= empty_d;
      idle_q  <= idle_d;
    end
  end

  assign empty = empty_q;
  assign idle  = idle_q;

  // R10
  swreset_tx_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> (empty_q && idle_q));

  // R6
  tx_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_write && !tx_take && !sw_reset) |=> !empty_q);

  // R7
  tx_take_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && !tx_done && !sw_reset) |=> !idle_q);

endmodule

// File: rtl/uart_line_ctl.sv
module uart_line_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_reset,
  input  logic rx_en,
  output logic rts,
  output logic abort
);

  logic rts_q, rts_d, abort_q;

  always_comb begin
    rts_d = rx_en & ~sw_reset;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rts_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      rts_q   <= rts_d;
      abort_q <= sw_reset;
    end
  end

  assign rts   = rts_q;
  assign abort = abort_q;

  // R11
  rts_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en || sw_reset) |=> !rts_q);

  // R10
  abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> abort_q);

endmodule

// File: rtl/uart_flag_irq.sv
module uart_flag_irq
  import uart_flag_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_reset_i,
  input  logic              err_clr_i,
  input  logic              rx_en_i,
  input  logic              rx_ie_i,
  input  logic              tx_ie_i,
  input  logic              idle_ie_i,
  input  logic              rx_load_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic              rx_parity_bad_i,
  input  logic              rx_frame_bad_i,
  input  logic              data_read_i,
  input  logic              tx_write_i,
  input  logic              tx_take_i,
  input  logic              tx_done_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_full_o,
  output logic              parity_err_o,
  output logic              frame_err_o,
  output logic              overrun_err_o,
  output logic              tx_empty_o,
  output logic              line_idle_o,
  output logic              rx_irq_o,
  output logic              tx_irq_o,
  output logic              idle_irq_o,
  output logic              rts_o,
  output logic              abort_o
);

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n = rst_sync_q[SYNC_STAGES-1];

  rx_err_t rx_err;
  logic    rx_full, tx_empty, line_idle;

  uart_rx_flags #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk_i),
    .rst_n    (rst_n),
    .sw_reset (sw_reset_i),
    .rx_en    (rx_en_i),
    .rx_load  (rx_load_i),
    .rx_byte  (rx_byte_i),
    .par_bad  (rx_parity_bad_i),
    .frm_bad  (rx_frame_bad_i),
    .data_read(data_read_i),
    .err_clr  (err_clr_i),
    .full     (rx_full),
    .err      (rx_err),
    .data     (rx_data_o)
  );

  uart_tx_flags u_tx (
    .clk     (clk_i),
    .rst_n   (rst_n),
    .sw_reset(sw_reset_i),
    .tx_write(tx_write_i),
    .tx_take (tx_take_i),
    .tx_done (tx_done_i),
    .empty   (tx_empty),
    .idle    (line_idle)
  );

  uart_line_ctl u_line (
    .clk     (clk_i),
    .rst_n   (rst_n),
    .sw_reset(sw_reset_i),
    .rx_en   (rx_en_i),
    .rts     (rts_o),
    .abort   (abort_o)
  );

  always_comb begin
    rx_irq_o   = rx_ie_i & (rx_full | rx_err.parity | rx_err.frame | rx_err.overrun);
    tx_irq_o   = tx_ie_i & tx_empty;
    idle_irq_o = idle_ie_i & line_idle;
  end

  assign rx_full_o     = rx_full;
  assign parity_err_o  = rx_err.parity;
  assign frame_err_o   = rx_err.frame;
  assign overrun_err_o = rx_err.overrun;
  assign tx_empty_o    = tx_empty;
  assign line_idle_o   = line_idle;

  // R8
  swreset_rx_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    sw_reset_i |=> !rx_irq_o);

  // R9
  tx_irq_after_swreset_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sw_reset_i && tx_ie_i) |=> (tx_irq_o || !tx_ie_i));

endmodule

// File: tb/uart_flag_irq_bench.sv
module uart_flag_irq_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic sw_reset, err_clr, rx_en, rx_ie, tx_ie, idle_ie;
  logic rx_load, par_bad, frm_bad, data_read, tx_write, tx_take, tx_done;
  logic [W-1:0] rx_byte;
  logic [W-1:0] rx_data;
  logic rx_full, pe, fe, ore, tx_empty, idle, rx_irq, tx_irq, idle_irq, rts, abort;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // bench model
  logic [W-1:0] m_data;
  logic m_full, m_pe, m_fe, m_ore, m_empty, m_idle, m_rts, m_abort;

  always #5 clk = ~clk;

  uart_flag_irq #(.DATA_W(W)) u_uart_flag_irq (
    .clk_i(clk), .rst_ni(rst_n), .sw_reset_i(sw_reset), .err_clr_i(err_clr),
    .rx_en_i(rx_en), .rx_ie_i(rx_ie), .tx_ie_i(tx_ie), .idle_ie_i(idle_ie),
    .rx_load_i(rx_load), .rx_byte_i(rx_byte), .rx_parity_bad_i(par_bad),
    .rx_frame_bad_i(frm_bad), .data_read_i(data_read), .tx_write_i(tx_write),
    .tx_take_i(tx_take), .tx_done_i(tx_done), .rx_data_o(rx_data),
    .rx_full_o(rx_full), .parity_err_o(pe), .frame_err_o(fe), .overrun_err_o(ore),
    .tx_empty_o(tx_empty), .line_idle_o(idle), .rx_irq_o(rx_irq), .tx_irq_o(tx_irq),
    .idle_irq_o(idle_irq), .rts_o(rts), .abort_o(abort)
  );

  function automatic logic exp_rx_irq(logic ie, logic f, logic p, logic fr, logic o);
    return ie & (f | p | fr | o);
  endfunction

  function automatic logic exp_gate(logic ie, logic flag);
    return ie & flag;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset_flags();
    m_full = 1'b0; m_pe = 1'b0; m_fe = 1'b0; m_ore = 1'b0;
    m_empty = 1'b1; m_idle = 1'b1;
  endtask

  task automatic model_step();
    logic acc, ovr, st;
    acc = rx_load & rx_en;
    ovr = acc & m_full & ~data_read;
    st  = acc & ~ovr;
    m_abort = sw_reset;
    m_rts   = rx_en & ~sw_reset;
    if (sw_reset) begin
      model_reset_flags();
    end else begin
      if (err_clr) begin m_pe = 1'b0; m_fe = 1'b0; m_ore = 1'b0; end
      if (data_read) m_full = 1'b0;
      if (st) begin
        m_full = 1'b1;
        m_data = rx_byte;
        if (par_bad) m_pe = 1'b1;
        if (frm_bad) m_fe = 1'b1;
      end
      if (ovr) m_ore = 1'b1;
      if (tx_write) m_empty = 1'b0;
      if (tx_take) begin m_empty = 1'b1; m_idle = 1'b0; end
      if (tx_done) m_idle = 1'b1;
    end
  endtask

  task automatic check_all();
    chk("R2 rx_full", rx_full, m_full);
    chk("R2 rx_data", rx_data, m_data);
    chk("R4 parity", pe, m_pe);
    chk("R4 frame", fe, m_fe);
    chk("R3 overrun", ore, m_ore);
    chk("R6 tx_empty", tx_empty, m_empty);
    chk("R7 line_idle", idle, m_idle);
    chk("R8 rx_irq", rx_irq, exp_rx_irq(rx_ie, m_full, m_pe, m_fe, m_ore));
    chk("R9 tx_irq", tx_irq, exp_gate(tx_ie, m_empty));
    chk("R9 idle_irq", idle_irq, exp_gate(idle_ie, m_idle));
    chk("R11 rts", rts, m_rts);
    chk("R10 abort", abort, m_abort);
  endtask

  task automatic clear_strobes();
    sw_reset = 0; err_clr = 0; rx_load = 0; par_bad = 0; frm_bad = 0;
    data_read = 0; tx_write = 0; tx_take = 0; tx_done = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all();
    clear_strobes();
  endtask

  task automatic load(input logic [W-1:0] b, input logic p, input logic f);
    rx_load = 1; rx_byte = b; par_bad = p; frm_bad = f;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    rst_n = 0;
    clear_strobes();
    rx_en = 0; rx_ie = 1; tx_ie = 1; idle_ie = 1; rx_byte = '0;
    model_reset_flags(); m_data = '0; m_rts = 0; m_abort = 0;
    repeat (3) @(negedge clk);
    // R1 reset state while reset is held
    check_all();
    rst_n = 1;
    repeat (4) tick();   // R1 cycles after release

    // R2 basic load, then read
    rx_en = 1; tick();
    load(8'hA5, 0, 0); tick();
    data_read = 1; tick();
    // R3 overrun keeps old byte
    load(8'h11, 0, 0); tick();
    load(8'h22, 1, 1); tick();
    // R2 load and read same cycle: load wins, no overrun
    err_clr = 1; tick();
    load(8'h33, 0, 0); data_read = 1; tick();
    // R5 clear colliding with an erroneous load
    data_read = 1; tick();
    load(8'h44, 1, 0); err_clr = 1; tick();
    // R12 load ignored while disabled
    rx_en = 0; data_read = 1; err_clr = 1; tick();
    load(8'h55, 1, 1); tick();
    rx_en = 1; tick();
    // R6 / R7 collisions
    tx_write = 1; tick();
    tx_write = 1; tx_take = 1; tick();
    tx_take = 1; tick();
    tx_take = 1; tx_done = 1; tick();
    // R10 software reset on top of other strobes
    load(8'h66, 1, 1); tick();
    tx_write = 1; tx_take = 1; tick();
    sw_reset = 1; load(8'h77, 1, 1); tx_write = 1; tx_take = 1; err_clr = 0; tick();
    tick();

    // random phase
    for (int i = 0; i < 4000; i++) begin
      rx_en    = ($urandom_range(99) < 85);
      rx_ie    = $urandom_range(1);
      tx_ie    = $urandom_range(1);
      idle_ie  = $urandom_range(1);
      rx_load  = ($urandom_range(99) < 35);
      rx_byte  = W'($urandom);
      par_bad  = ($urandom_range(99) < 15);
      frm_bad  = ($urandom_range(99) < 15);
      data_read = ($urandom_range(99) < 30);
      err_clr  = ($urandom_range(99) < 10);
      sw_reset = ($urandom_range(99) < 3);
      tx_write = ($urandom_range(99) < 30);
      tx_take  = ($urandom_range(99) < 25);
      tx_done  = ($urandom_range(99) < 20);
      tick();
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule